// File: doc/BRIEF.md
# Strided Block Transfer Engine

This engine copies data between off-chip memory and an on-chip scratchpad without involving the processor for each word. Software writes a transfer description through a small configuration port and then pulses a start input. The description holds a source address, a destination address, the words per block, the block count, the distance between the starts of consecutive blocks, the direction and a cap on outstanding reads. The engine walks the block pattern over off-chip memory one 32-bit word per beat. Only the words that belong to the blocks cross the off-chip bus. On the scratchpad side the words sit back to back.

A load reads off-chip memory and packs the returned words into the scratchpad. Reads are pipelined: a new one may go out each cycle while earlier ones are still in flight, up to the programmed cap. Responses return in request order after a fixed latency. A store reads the scratchpad sequentially and posts each word as an off-chip write at the matching pattern address. A contiguous page move is the case where the stride equals the block size, or where the block size is 1 and the stride is 1. All addresses are word addresses.

Top module: `block_stride_dma`

## Requirements
- R1: In a load (direction bit 0 = 0), beat k issues a read (memReqValid=1, memReqWrite=0) at address src + (k / words) * stride + (k mod words), for k = 0 .. words*blocks-1 in increasing order.
- R2: In a load, the j-th read response (memRespValid=1) is written in that same cycle to the scratchpad at dst + j with the response data (spWe=1, spWdata=memRespRdata).
- R3: In a store (direction bit 0 = 1), the engine reads the scratchpad at dst + k in consecutive cycles (spRe=1). The word read is returned on spRdata one cycle later and goes out in that cycle as an off-chip write (memReqWrite=1) at the R1 pattern address for beat k.
- R4: The count of reads that are issued but have not yet been answered never exceeds the cap, and a cap of 0 acts as 1. A read goes out in every load cycle in which words remain and fewer reads than the cap are in flight.
- R5: A configuration write (cfgWe=1) loads the field chosen by cfgSel: 0 source, 1 destination, 2 words per block, 3 block count, 4 stride, 5 direction in bit 0, 6 outstanding cap in the low bits.
- R6: A start with words per block, block count or stride equal to zero makes no off-chip or scratchpad access and raises done in the next cycle with busy staying low.
- R7: Configuration writes made while busy is high leave the fields unchanged. A later transfer uses the values held before busy rose.
- R8: busy rises in the cycle after an accepted start. busy falls and done rises in the cycle after the last beat (the last scratchpad write of a load, or the last off-chip write of a store). done stays high until the next start, and a start while busy has no effect.
- R9: During and right after reset, busy and done are low and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Field select for a configuration write |
| cfgData | input | DATA_W | Configuration write value |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| memReqValid | output | 1 | Off-chip request this cycle |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqAddr | output | ADDR_W | Off-chip word address |
| memReqWdata | output | DATA_W | Off-chip write data |
| memRespValid | input | 1 | Read data returning |
| memRespRdata | input | DATA_W | Read data |
| spWe | output | 1 | Scratchpad write strobe |
| spRe | output | 1 | Scratchpad read strobe |
| spAddr | output | ADDR_W | Scratchpad word address |
| spWdata | output | DATA_W | Scratchpad write data |
| spRdata | input | DATA_W | Scratchpad read data, one cycle after spRe |

## Verification
The assertions assume that off-chip memory accepts every request at once and that it answers each read exactly once, in order, never with an unrequested response. They also assume that the scratchpad returns read data on the cycle after the strobe. The bench memory keeps these rules by answering each read from a queue exactly 40 cycles after the request. It answers nothing during stores, and it feeds spRdata from the previous cycle's scratchpad address. Configuration changes made under busy are issued on purpose to test R7. The cap tracking in the checker relies on the engine ignoring them.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} bst_state_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic init;     // latch source and destination into the walkers
    logic memStep;  // advance the off-chip pattern walker
    logic spStep;   // advance the scratchpad pointer
    logic rdReq;    // issue an off-chip read
    logic wrReq;    // issue an off-chip write
    logic spWr;     // write a returned word to the scratchpad
    logic spRd;     // read a word from the scratchpad
  } bst_strobe_t;

endpackage

// File: rtl/bst_datapath.sv
module bst_datapath
  import bst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int OUT_W  = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busy,
  input  logic                  cfgWe,
  input  logic [2:0]            cfgSel,
  input  logic [DATA_W-1:0]     cfgData,
  input  bst_strobe_t           strb,
  output logic [2*LEN_W-1:0]    totalBeats,
  output logic [OUT_W-1:0]      outLimit,
  output logic                  dirStore,
  output logic                  isEmpty,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [DATA_W-1:0]     memReqWdata,
  input  logic [DATA_W-1:0]     memRespRdata,
  output logic                  spWe,
  output logic                  spRe,
  output logic [ADDR_W-1:0]     spAddr,
  output logic [DATA_W-1:0]     spWdata,
  input  logic [DATA_W-1:0]     spRdata
);

  localparam int TOT_W = 2 * LEN_W;

  logic [ADDR_W-1:0] srcReg, dstReg, strideReg;
  logic [LEN_W-1:0]  wordsReg, blocksReg;
  logic [OUT_W-1:0]  capReg;
  logic              dirReg;

  logic [ADDR_W-1:0] blkBase, spPtr;
  logic [LEN_W-1:0]  wordIdx;
  logic              blockEnd;

  // Configuration fields, frozen while a transfer runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg    <= '0;
      dstReg    <= '0;
      strideReg <= '0;
      wordsReg  <= '0;
      blocksReg <= '0;
      capReg    <= '0;
      dirReg    <= 1'b0;
    end else if (cfgWe && !busy) begin
      case (cfgSel)
        3'd0:    srcReg    <= cfgData[ADDR_W-1:0];
        3'd1:    dstReg    <= cfgData[ADDR_W-1:0];
        3'd2:    wordsReg  <= cfgData[LEN_W-1:0];
        3'd3:    blocksReg <= cfgData[LEN_W-1:0];
        3'd4:    strideReg <= cfgData[ADDR_W-1:0];
        3'd5:    dirReg    <= cfgData[0];
        3'd6:    capReg    <= cfgData[OUT_W-1:0];
        default: ;
      endcase
    end
  end

  assign totalBeats = TOT_W'(wordsReg) * TOT_W'(blocksReg);
  assign outLimit   = capReg;
  assign dirStore   = dirReg;
  assign isEmpty    = (wordsReg == '0) || (blocksReg == '0) || (strideReg == '0);

  // Pattern walker: block base plus word offset, no per-beat multiply
  assign blockEnd = (wordIdx == wordsReg - LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkBase <= '0;
      wordIdx <= '0;
      spPtr   <= '0;
    end else begin
      if (strb.init) begin
        blkBase <= srcReg;
        wordIdx <= '0;
      end else if (strb.memStep) begin
        if (blockEnd) begin
          blkBase <= blkBase + strideReg;
          wordIdx <= '0;
        end else begin
          wordIdx <= wordIdx + LEN_W'(1);
        end
      end
      if (strb.init)        spPtr <= dstReg;
      else if (strb.spStep) spPtr <= spPtr + ADDR_W'(1);
    end
  end

  assign memReqValid = strb.rdReq | strb.wrReq;
  assign memReqWrite = strb.wrReq;
  assign memReqAddr  = blkBase + ADDR_W'(wordIdx);
  assign memReqWdata = spRdata;
  assign spWe        = strb.spWr;
  assign spRe        = strb.spRd;
  assign spAddr      = spPtr;
  assign spWdata     = memRespRdata;

endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
#(
  parameter int TOT_W = 32,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirStore,
  input  logic             isEmpty,
  input  logic             memRespValid,
  input  logic [TOT_W-1:0] totalBeats,
  input  logic [OUT_W-1:0] outLimit,
  output bst_strobe_t      strb,
  output logic             busy,
  output logic             done
);

  bst_state_t       state;
  logic [TOT_W-1:0] issued, completed, inFlight;
  logic [OUT_W-1:0] limEff;
  logic             rdPend, moreToIssue, beat, lastBeat, issueNow;

  always_comb begin
    limEff      = (outLimit == '0) ? OUT_W'(1) : outLimit;
    inFlight    = issued - completed;
    moreToIssue = issued < totalBeats;
    strb        = '0;
    beat        = 1'b0;
    if (state == ST_IDLE) begin
      strb.init = start && !isEmpty;
    end else if (!dirStore) begin
      strb.rdReq   = moreToIssue && (inFlight < TOT_W'(limEff));
      strb.memStep = strb.rdReq;
      strb.spWr    = memRespValid;
      strb.spStep  = memRespValid;
      beat         = memRespValid;
    end else begin
      strb.spRd    = moreToIssue;
      strb.spStep  = moreToIssue;
      strb.wrReq   = rdPend;
      strb.memStep = rdPend;
      beat         = rdPend;
    end
    issueNow = strb.rdReq | strb.spRd;
    lastBeat = beat && (completed == totalBeats - TOT_W'(1));
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      issued    <= '0;
      completed <= '0;
      rdPend    <= 1'b0;
      done      <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        done      <= isEmpty;
        state     <= isEmpty ? ST_IDLE : ST_RUN;
        issued    <= '0;
        completed <= '0;
        rdPend    <= 1'b0;
      end
    end else begin
      if (issueNow) issued    <= issued + TOT_W'(1);
      if (beat)     completed <= completed + TOT_W'(1);
      rdPend <= strb.spRd;
      if (lastBeat) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/block_stride_dma.sv
module block_stride_dma
  import bst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int OUT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespRdata,
  output logic              spWe,
  output logic              spRe,
  output logic [ADDR_W-1:0] spAddr,
  output logic [DATA_W-1:0] spWdata,
  input  logic [DATA_W-1:0] spRdata
);

  localparam int TOT_W = 2 * LEN_W;

  bst_strobe_t      strb;
  logic [TOT_W-1:0] totalBeats;
  logic [OUT_W-1:0] outLimit;
  logic             dirStore, isEmpty;

  bst_ctrl #(.TOT_W(TOT_W), .OUT_W(OUT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .dirStore     (dirStore),
    .isEmpty      (isEmpty),
    .memRespValid (memRespValid),
    .totalBeats   (totalBeats),
    .outLimit     (outLimit),
    .strb         (strb),
    .busy         (busy),
    .done         (done)
  );

  bst_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .OUT_W(OUT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .busy         (busy),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .cfgData      (cfgData),
    .strb         (strb),
    .totalBeats   (totalBeats),
    .outLimit     (outLimit),
    .dirStore     (dirStore),
    .isEmpty      (isEmpty),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .memReqAddr   (memReqAddr),
    .memReqWdata  (memReqWdata),
    .memRespRdata (memRespRdata),
    .spWe         (spWe),
    .spRe         (spRe),
    .spAddr       (spAddr),
    .spWdata      (spWdata),
    .spRdata      (spRdata)
  );

endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int OUT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cfgWe,
  input logic [2:0]       cfgSel,
  input logic [OUT_W-1:0] cfgLow,
  input logic             memReqValid,
  input logic             memReqWrite,
  input logic             memRespValid,
  input logic             spWe,
  input logic             spRe
);

  logic [OUT_W-1:0] capSeen, capEff;
  logic             dirSeen;
  logic [OUT_W:0]   outCnt;

  // Independent shadow of the cap and direction, seen from the port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSeen <= '0;
      dirSeen <= 1'b0;
      outCnt  <= '0;
    end else begin
      if (cfgWe && !busy && cfgSel == 3'd6) capSeen <= cfgLow;
      if (cfgWe && !busy && cfgSel == 3'd5) dirSeen <= cfgLow[0];
      outCnt <= outCnt + (OUT_W+1)'(memReqValid && !memReqWrite)
                       - (OUT_W+1)'(memRespValid);
    end
  end

  assign capEff = (capSeen == '0) ? OUT_W'(1) : capSeen;

  assert_out_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (outCnt < {1'b0, capEff}));

  assert_dir_follows_cfg_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqWrite == dirSeen));

  assert_traffic_only_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || spWe || spRe) |-> busy);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_sp_one_port_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(spWe && spRe));

endmodule

bind block_stride_dma bst_checker #(.OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .cfgWe        (cfgWe),
  .cfgSel       (cfgSel),
  .cfgLow       (cfgData[OUT_W-1:0]),
  .memReqValid  (memReqValid),
  .memReqWrite  (memReqWrite),
  .memRespValid (memRespValid),
  .spWe         (spWe),
  .spRe         (spRe)
);

// File: tb/block_stride_dma_tb.sv
`timescale 1ns/1ps
module block_stride_dma_tb;

  localparam int LAT = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic        memReqValid, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespRdata = '0;
  logic        spWe, spRe;
  logic [31:0] spAddr, spWdata;
  logic [31:0] spRdata = '0;

  always #5 clk = ~clk;

  block_stride_dma u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .start(start), .busy(busy), .done(done),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRespValid(memRespValid), .memRespRdata(memRespRdata),
    .spWe(spWe), .spRe(spRe), .spAddr(spAddr), .spWdata(spWdata), .spRdata(spRdata)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  int wdog = 0;
  string curTag = "R9";

  // Reference model state
  logic [31:0] mSrc = 0, mDst = 0, mWords = 0, mBlocks = 0, mStride = 0, mCap = 0;
  logic        mDir = 0;
  logic        mBusy = 0, mDone = 0, mRdPend = 0;
  logic [31:0] mIssued = 0, mCompleted = 0, mTotal = 0;

  int          dueQ[$];
  logic [31:0] dataQ[$];
  logic [31:0] spNext = 0;

  function automatic logic [31:0] memData(logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hA5A5_5A5A;
  endfunction

  function automatic logic [31:0] spData(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] patAddr(logic [31:0] k);
    return mSrc + (k / mWords) * mStride + (k % mWords);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic        respV, eReq, eWr, eSpWe, eSpRe, beat, isEmpty;
    logic [31:0] respD, eAddr, eWdata, eSpAddr, eSpWdata, cap;
    respV = 0; respD = 0;
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      respV = 1; respD = dataQ[0];
      void'(dueQ.pop_front()); void'(dataQ.pop_front());
    end
    memRespValid = respV;
    memRespRdata = respD;
    spRdata = spNext;
    #1;
    eReq = 0; eWr = 0; eSpWe = 0; eSpRe = 0; beat = 0;
    eAddr = 0; eWdata = 0; eSpAddr = 0; eSpWdata = 0;
    cap = (mCap == 0) ? 32'd1 : mCap;
    if (mBusy && rstN) begin
      if (!mDir) begin
        if (mIssued < mTotal && (mIssued - mCompleted) < cap) begin
          eReq = 1; eAddr = patAddr(mIssued);
        end
        if (respV) begin
          eSpWe = 1; eSpAddr = mDst + mCompleted; eSpWdata = respD; beat = 1;
        end
      end else begin
        if (mIssued < mTotal) begin
          eSpRe = 1; eSpAddr = mDst + mIssued;
        end
        if (mRdPend) begin
          eReq = 1; eWr = 1; eAddr = patAddr(mCompleted);
          eWdata = spData(mDst + mCompleted); beat = 1;
        end
      end
    end
    // Per-cycle comparison against the model
    chk("R8", "busy", busy, mBusy);
    chk("R8", "done", done, mDone);
    chk(curTag, "memReqValid", memReqValid, eReq);
    chk(curTag, "spWe", spWe, eSpWe);
    chk(curTag, "spRe", spRe, eSpRe);
    if (eReq) begin
      chk("R3", "memReqWrite", memReqWrite, eWr);
      chk("R1", "memReqAddr", memReqAddr, eAddr);
      if (eWr) chk("R3", "memReqWdata", memReqWdata, eWdata);
    end
    if (eSpWe || eSpRe) chk("R2", "spAddr", spAddr, eSpAddr);
    if (eSpWe) chk("R2", "spWdata", spWdata, eSpWdata);
    // Model update for the coming edge
    if (rstN) begin
      if (!mBusy) begin
        if (start) begin
          isEmpty = (mWords == 0) || (mBlocks == 0) || (mStride == 0);
          mDone = isEmpty;
          if (!isEmpty) begin
            mBusy = 1; mIssued = 0; mCompleted = 0; mRdPend = 0;
            mTotal = mWords * mBlocks;
          end
        end
        if (cfgWe) begin
          case (cfgSel)  // R5 field selects
            3'd0: mSrc = cfgData;
            3'd1: mDst = cfgData;
            3'd2: mWords = {16'd0, cfgData[15:0]};
            3'd3: mBlocks = {16'd0, cfgData[15:0]};
            3'd4: mStride = cfgData;
            3'd5: mDir = cfgData[0];
            3'd6: mCap = {26'd0, cfgData[5:0]};
            default: ;
          endcase
        end
      end else begin
        if (eReq && !eWr) mIssued++;
        if (eSpRe) mIssued++;
        mRdPend = eSpRe;
        if (beat) begin
          mCompleted++;
          if (mCompleted == mTotal) begin mBusy = 0; mDone = 1; end
        end
      end
    end
    // Bench memory and scratchpad react to what the design actually drove
    if (memReqValid === 1'b1 && memReqWrite === 1'b0) begin
      dueQ.push_back(cyc + LAT);
      dataQ.push_back(memData(memReqAddr));
    end
    spNext = (spRe === 1'b1) ? spData(spAddr) : 32'h0;
    @(negedge clk);
    cyc++;
  endtask

  task automatic cfg(logic [2:0] sel, logic [31:0] val);
    cfgWe = 1; cfgSel = sel; cfgData = val;
    step();
    cfgWe = 0; cfgSel = 0; cfgData = 0;
  endtask

  task automatic setup(logic [31:0] s, logic [31:0] d, logic [31:0] w,
                       logic [31:0] b, logic [31:0] st, logic dir, logic [31:0] cp);
    cfg(3'd0, s); cfg(3'd1, d); cfg(3'd2, w); cfg(3'd3, b);
    cfg(3'd4, st); cfg(3'd5, {31'd0, dir}); cfg(3'd6, cp);
  endtask

  task automatic go();
    start = 1; step(); start = 0;
  endtask

  task automatic finishRun();
    for (int i = 0; i < 4000 && !mDone; i++) step();
    step();
    chk("R8", "done after run", done, 1'b1);
  endtask

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 150000) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    curTag = "R9";
    for (int i = 0; i < 3; i++) step();
    rstN = 1;
    for (int i = 0; i < 2; i++) step();

    // R1 R2 R5: strided load, 3 words x 4 blocks, stride 10, cap 8
    curTag = "R1";
    setup(32'h100, 32'h20, 3, 4, 10, 0, 8);
    go(); finishRun();

    // R4: cap 0 behaves as 1, one read in flight at a time
    curTag = "R4";
    setup(32'h4000, 32'h80, 2, 2, 5, 0, 0);
    go(); finishRun();

    // R4: contiguous page load with a wide cap, one read per cycle
    setup(32'h800, 32'h0, 1, 8, 1, 0, 63);
    go(); finishRun();

    // R3: strided store, 2 words x 3 blocks, stride 7
    curTag = "R3";
    setup(32'h2000, 32'h40, 2, 3, 7, 1, 4);
    go(); finishRun();

    // R6: empty transfers, count zero then stride zero then words zero
    curTag = "R6";
    setup(32'h10, 32'h10, 4, 0, 4, 0, 4);
    go(); step(); chk("R6", "done after empty start", done, 1'b1);
    cfg(3'd3, 2); cfg(3'd4, 0);
    go(); step(); chk("R6", "busy after empty start", busy, 1'b0);
    cfg(3'd4, 3); cfg(3'd2, 0);
    go(); step(); chk("R6", "done after empty start", done, 1'b1);

    // R7 R8: config writes and a second start while busy are ignored
    curTag = "R7";
    setup(32'h300, 32'h100, 2, 3, 4, 0, 2);
    go();
    cfg(3'd0, 32'hFFF0); cfg(3'd5, 1); cfg(3'd6, 1);
    start = 1; step(); start = 0;
    finishRun();
    curTag = "R8";
    for (int i = 0; i < 3; i++) step();
    chk("R8", "done holds", done, 1'b1);
    go(); finishRun();  // reuses held fields (R7)

    for (int i = 0; i < 3; i++) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule